// File: doc/BRIEF.md
# Fault-Injectable Bit RAM

A small single-port RAM, one bit wide and parameter-deep, for memory self-test experiments. Its fault port selects one functional fault class together with a victim cell, an aggressor cell, a trigger polarity and a forced value. When the fault code is zero the block is an ordinary synchronous RAM. This lets the same model serve both as the reference and as the device under test.

While a fault is selected, the block changes the stored array or the returned read bit on each clock edge, as the chosen class defines. The fault fields are captured only in cycles where chip enable is low. A self-test engine can therefore run a complete march sequence against a fixed fault. It then returns to an idle cycle to load the next fault. Read data is registered and appears one cycle after the read request.

Top module: `fault_ram`

## Requirements
- R1: With fault code 0, a write (ce=1, we=1) stores din at addr. A read (ce=1, we=0) presents the stored bit on dout after the next rising edge. dout holds its value in every cycle that is not a read.
- R2: The fault fields (type, victim, aggressor, polarity, forced value) are captured on a rising edge only when ce=0. Changes made while ce=1 have no effect until an idle cycle. Codes: 0 none, 1 stuck, 2 transition, 3 read-disturb, 4 deceptive read-disturb, 5 incorrect-read, 6 write-disturb, 7 inversion coupling, 8 idempotent coupling, 9 state coupling, 10 AND bridge, 11 OR bridge.
- R3: Stuck (1): the victim always reads and holds the polarity value, and writes to it have no effect.
- R4: Transition (2): with polarity 1, a 0-to-1 write on the victim is dropped. With polarity 0, a 1-to-0 write is dropped. Every other write behaves normally.
- R5: Read-disturb (3): a victim read returns the inverse of the stored bit, and the stored bit flips to that returned value.
- R6: Deceptive read-disturb (4): a victim read returns the stored bit, then the stored bit flips. A second read in a row shows the changed value.
- R7: Incorrect-read (5): a victim read returns the inverse of the stored bit, and the stored bit is left unchanged.
- R8: Write-disturb (6): a write that stores the value the victim already holds leaves the victim inverted.
- R9: Inversion coupling (7): a write that takes the aggressor 0-to-1 (polarity 1) or 1-to-0 (polarity 0) inverts the victim. Writes that cause no such transition leave the victim alone.
- R10: Idempotent coupling (8): the selected aggressor transition sets the victim to the forced value.
- R11: State coupling (9): in every cycle where the aggressor holds the polarity value, the victim is set to the forced value. This overrides a write to the victim in the same cycle.
- R12: Bridges (10 AND, 11 OR): after every edge, victim and aggressor both hold the AND, or the OR, of their fault-free values.
- R13: Reset (rst_n low) clears every cell, the fault fields and dout to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Chip enable; low cycles load the fault fields |
| we | input | 1 | 1 write, 0 read when ce is high |
| addr | input | AW | Cell address |
| din | input | 1 | Write data |
| dout | output | 1 | Registered read data |
| flt_type | input | 4 | Fault class code (R2) |
| flt_victim | input | AW | Victim cell address |
| flt_aggr | input | AW | Aggressor cell address |
| flt_pol | input | 1 | Stuck value, blocked transition, trigger edge or aggressor state |
| flt_val | input | 1 | Value forced onto the victim by idempotent and state coupling |

## Verification
The case that needs the most care is a write to the victim landing in the same cycle as a fault action on that victim. For state coupling, the aggressor is set to the trigger state and the opposite value is then written to the victim. The following read must show the forced value, not the written one. For stuck and bridge faults, the same kind of write is judged by reading both cells back. Reads on a disturb fault change the array in the same edge that registers the output. Repeated back-to-back reads therefore check that dout carries the value from before the edge, while the next read sees the flipped bit.

// File: rtl/fault_ram_pkg.sv
package fault_ram_pkg;

  typedef enum logic [3:0] {
    FK_NONE   = 4'd0,
    FK_STUCK  = 4'd1,
    FK_TRANS  = 4'd2,
    FK_RDIST  = 4'd3,
    FK_DRDIST = 4'd4,
    FK_IRD    = 4'd5,
    FK_WRDIST = 4'd6,
    FK_CINV   = 4'd7,
    FK_CIDEM  = 4'd8,
    FK_CSTATE = 4'd9,
    FK_BAND   = 4'd10,
    FK_BOR    = 4'd11
  } fault_kind_e;

  typedef struct packed {
    fault_kind_e kind;
    logic        pol;
    logic        fval;
  } fault_cfg_t;

endpackage

// File: rtl/fault_ram_cfg.sv
module fault_ram_cfg
  import fault_ram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_q_n,
  input  logic          ce,
  input  logic [3:0]    type_i,
  input  logic [AW-1:0] vict_i,
  input  logic [AW-1:0] aggr_i,
  input  logic          pol_i,
  input  logic          val_i,
  output fault_cfg_t    cfg_o,
  output logic [AW-1:0] vict_o,
  output logic [AW-1:0] aggr_o
);

  logic          load_en;
  fault_cfg_t    cfg_d;
  logic [AW-1:0] vict_d;
  logic [AW-1:0] aggr_d;

  assign load_en = !ce;

  always_comb begin
    cfg_d  = cfg_o;
    vict_d = vict_o;
    aggr_d = aggr_o;
    if (load_en) begin
      cfg_d.kind = fault_kind_e'(type_i);
      cfg_d.pol  = pol_i;
      cfg_d.fval = val_i;
      vict_d     = vict_i;
      aggr_d     = aggr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cfg_o  <= '{kind: FK_NONE, pol: 1'b0, fval: 1'b0};
      vict_o <= '0;
      aggr_o <= '0;
    end else begin
      cfg_o  <= cfg_d;
      vict_o <= vict_d;
      aggr_o <= aggr_d;
    end
  end

endmodule

// File: rtl/fault_ram_next.sv
module fault_ram_next
  import fault_ram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cur,
  input  logic             ce,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic             din,
  input  fault_cfg_t       cfg,
  input  logic [AW-1:0]    vict,
  input  logic [AW-1:0]    aggr,
  output logic [DEPTH-1:0] nxt,
  output logic             rd_bit
);

  logic old_b;
  logic new_b;
  logic fire;
  logic tie;
  logic two_cell;

  assign two_cell = (vict != aggr);

  // array next state: write-path faults, then read flips, coupling, stuck, bridges
  always_comb begin
    nxt   = cur;
    old_b = cur[addr];
    new_b = din;
    fire  = 1'b0;
    tie   = 1'b0;
    if (ce && we) begin
      if (addr == vict) begin
        case (cfg.kind)
          FK_TRANS:  if (cfg.pol ? (!old_b && din) : (old_b && !din)) new_b = old_b;
          FK_WRDIST: if (din == old_b) new_b = !old_b;
          default: ;
        endcase
      end
      nxt[addr] = new_b;
      if ((addr == aggr) && two_cell)
        fire = cfg.pol ? (!old_b && new_b) : (old_b && !new_b);
    end
    if (ce && !we && (addr == vict) &&
        ((cfg.kind == FK_RDIST) || (cfg.kind == FK_DRDIST)))
      nxt[vict] = !cur[vict];
    if (fire && (cfg.kind == FK_CINV))  nxt[vict] = !cur[vict];
    if (fire && (cfg.kind == FK_CIDEM)) nxt[vict] = cfg.fval;
    if ((cfg.kind == FK_CSTATE) && two_cell && (nxt[aggr] == cfg.pol))
      nxt[vict] = cfg.fval;
    if (cfg.kind == FK_STUCK) nxt[vict] = cfg.pol;
    if (two_cell && ((cfg.kind == FK_BAND) || (cfg.kind == FK_BOR))) begin
      tie = (cfg.kind == FK_BAND) ? (nxt[vict] & nxt[aggr]) : (nxt[vict] | nxt[aggr]);
      nxt[vict] = tie;
      nxt[aggr] = tie;
    end
  end

  // read-path faults
  always_comb begin
    rd_bit = cur[addr];
    if (addr == vict) begin
      case (cfg.kind)
        FK_STUCK:        rd_bit = cfg.pol;
        FK_RDIST, FK_IRD: rd_bit = !cur[vict];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fault_ram.sv
module fault_ram
  import fault_ram_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic          din,
  output logic          dout,
  input  logic [3:0]    flt_type,
  input  logic [AW-1:0] flt_victim,
  input  logic [AW-1:0] flt_aggr,
  input  logic          flt_pol,
  input  logic          flt_val
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q_n;
  fault_cfg_t             cfg_q;
  logic [AW-1:0]          vict_q;
  logic [AW-1:0]          aggr_q;
  logic [DEPTH-1:0]       mem_q;
  logic [DEPTH-1:0]       mem_d;
  logic                   rd_bit;
  logic                   rd_en;
  logic                   dout_d;

  // reset: asserted at once, released after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_STAGES-1];

  fault_ram_cfg #(.AW(AW)) u_cfg (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .ce      (ce),
    .type_i  (flt_type),
    .vict_i  (flt_victim),
    .aggr_i  (flt_aggr),
    .pol_i   (flt_pol),
    .val_i   (flt_val),
    .cfg_o   (cfg_q),
    .vict_o  (vict_q),
    .aggr_o  (aggr_q)
  );

  fault_ram_next #(.DEPTH(DEPTH)) u_next (
    .cur    (mem_q),
    .ce     (ce),
    .we     (we),
    .addr   (addr),
    .din    (din),
    .cfg    (cfg_q),
    .vict   (vict_q),
    .aggr   (aggr_q),
    .nxt    (mem_d),
    .rd_bit (rd_bit)
  );

  assign rd_en  = ce && !we;
  assign dout_d = rd_en ? rd_bit : dout;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mem_q <= '0;
      dout  <= 1'b0;
    end else begin
      mem_q <= mem_d;
      dout  <= dout_d;
    end
  end

endmodule

// File: rtl/fault_ram_chk.sv
module fault_ram_chk
  import fault_ram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             ce,
  input logic             we,
  input logic [AW-1:0]    addr,
  input logic             din,
  input logic             dout,
  input logic [DEPTH-1:0] mem_q,
  input fault_kind_e      kind,
  input logic [AW-1:0]    vict,
  input logic [AW-1:0]    aggr,
  input logic             pol,
  input logic             fval
);

  AST_CLEAN_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kind == FK_NONE && ce && we) |=> mem_q[$past(addr)] == $past(din)); // R1

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(ce && !we) |=> $stable(dout)); // R1

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_q_n)
    ce |=> $stable({kind, vict, aggr, pol, fval})); // R2

  AST_STUCK_READ: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kind == FK_STUCK && ce && !we && addr == vict) |=> dout == $past(pol)); // R3

  AST_IRD_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (kind == FK_IRD && ce && !we && addr == vict)
      |=> (mem_q[vict] == $past(mem_q[vict])) && (dout != $past(mem_q[vict]))); // R7

  AST_BRIDGE_TIE: assert property (@(posedge clk) disable iff (!rst_q_n)
    ((kind == FK_BAND || kind == FK_BOR) && vict != aggr && ce)
      |=> mem_q[vict] == mem_q[aggr]); // R12

endmodule

bind fault_ram fault_ram_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ce      (ce),
  .we      (we),
  .addr    (addr),
  .din     (din),
  .dout    (dout),
  .mem_q   (mem_q),
  .kind    (cfg_q.kind),
  .vict    (vict_q),
  .aggr    (aggr_q),
  .pol     (cfg_q.pol),
  .fval    (cfg_q.fval)
);

// File: tb/fault_ram_tb.sv
`timescale 1ns/1ps
module fault_ram_tb;
  import fault_ram_pkg::*;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce, we, din;
  logic [AW-1:0] addr;
  logic          dout;
  logic [3:0]    flt_type;
  logic [AW-1:0] flt_victim, flt_aggr;
  logic          flt_pol, flt_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit   exp_q[$];
  string tag_q[$];
  logic rd_issue_d = 1'b0;

  always #10 clk = ~clk;

  fault_ram #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr), .din(din), .dout(dout),
    .flt_type(flt_type), .flt_victim(flt_victim), .flt_aggr(flt_aggr),
    .flt_pol(flt_pol), .flt_val(flt_val)
  );

  // monitor: a read issued before an edge is judged at the following falling edge
  always @(posedge clk) rd_issue_d <= rst_n && ce && !we;

  always @(negedge clk) begin
    if (rd_issue_d) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: dout=%0b with no expected item", dout);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (dout !== e) begin
          n_bad++;
          $display("FAIL %s: dout=%0b expected=%0b", t, dout, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      ce = 1'b0; we = 1'b0;
    end
  endtask

  task automatic wr(input int a, input bit d);
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = AW'(a); din = d;
  endtask

  task automatic rd(input int a, input bit e, input string t);
    @(negedge clk);
    ce = 1'b1; we = 1'b0; addr = AW'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic set_fault(input fault_kind_e k, input int v, input int ag,
                           input bit p, input bit fv);
    @(negedge clk);
    ce = 1'b0; we = 1'b0;
    flt_type = k; flt_victim = AW'(v); flt_aggr = AW'(ag);
    flt_pol = p; flt_val = fv;
  endtask

  task automatic do_reset();
    idle(2);
    @(negedge clk);
    rst_n = 1'b0;
    flt_type = FK_NONE; flt_victim = '0; flt_aggr = '0; flt_pol = 1'b0; flt_val = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(3);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b0; we = 1'b0; addr = '0; din = 1'b0;
    flt_type = FK_NONE; flt_victim = '0; flt_aggr = '0; flt_pol = 1'b0; flt_val = 1'b0;
    do_reset();

    // R13 reset state
    n_cmp++;
    if (dout !== 1'b0) begin
      n_bad++; $display("FAIL R13: dout=%0b expected=0", dout);
    end
    rd(3, 0, "R13"); rd(12, 0, "R13");

    // R1 plain RAM
    wr(3, 1); wr(4, 0); rd(3, 1, "R1"); rd(4, 0, "R1");
    wr(3, 0); idle(1); rd(3, 0, "R1"); idle(2);

    // R2: fault fields changed while ce high are ignored, then latched on idle
    @(negedge clk);
    ce = 1'b1; we = 1'b1; addr = AW'(7); din = 1'b0;
    flt_type = FK_STUCK; flt_victim = AW'(7); flt_pol = 1'b1;
    rd(7, 0, "R2");
    idle(1);
    rd(7, 1, "R3"); idle(2);

    // R3 stuck-at-0
    do_reset(); set_fault(FK_STUCK, 5, 9, 0, 0);
    wr(5, 1); rd(5, 0, "R3"); wr(6, 1); rd(6, 1, "R3"); idle(2);

    // R4 transition faults
    do_reset(); set_fault(FK_TRANS, 5, 9, 1, 0);
    wr(5, 1); rd(5, 0, "R4"); idle(2);
    do_reset(); set_fault(FK_TRANS, 5, 9, 0, 0);
    wr(5, 1); rd(5, 1, "R4"); wr(5, 0); rd(5, 1, "R4"); idle(2);

    // R5 read-disturb
    do_reset(); set_fault(FK_RDIST, 5, 9, 0, 0);
    wr(5, 1); rd(5, 0, "R5"); rd(5, 1, "R5"); idle(2);

    // R6 deceptive read-disturb
    do_reset(); set_fault(FK_DRDIST, 5, 9, 0, 0);
    wr(5, 1); rd(5, 1, "R6"); rd(5, 0, "R6"); rd(5, 1, "R6"); idle(2);

    // R7 incorrect read; stored bit revealed after clearing the fault
    do_reset(); set_fault(FK_IRD, 5, 9, 0, 0);
    wr(5, 1); rd(5, 0, "R7"); rd(5, 0, "R7");
    set_fault(FK_NONE, 5, 9, 0, 0); rd(5, 1, "R7"); idle(2);

    // R8 write-disturb
    do_reset(); set_fault(FK_WRDIST, 5, 9, 0, 0);
    wr(5, 0); rd(5, 1, "R8"); wr(5, 0); rd(5, 0, "R8"); idle(2);

    // R9 inversion coupling on aggressor rise
    do_reset(); set_fault(FK_CINV, 5, 9, 1, 0);
    wr(5, 1); wr(9, 1); rd(5, 0, "R9");
    wr(9, 1); rd(5, 0, "R9"); wr(9, 0); rd(5, 0, "R9"); rd(9, 0, "R9"); idle(2);

    // R10 idempotent coupling, fall forces 1
    do_reset(); set_fault(FK_CIDEM, 5, 9, 0, 1);
    wr(9, 1); rd(5, 0, "R10"); wr(9, 0); rd(5, 1, "R10"); idle(2);

    // R11 state coupling, aggressor at 1 forces victim 0, even against a same-cycle write
    do_reset(); set_fault(FK_CSTATE, 5, 9, 1, 0);
    wr(5, 1); rd(5, 1, "R11"); wr(9, 1); rd(5, 0, "R11");
    wr(5, 1); rd(5, 0, "R11");
    wr(9, 0); wr(5, 1); rd(5, 1, "R11"); idle(2);

    // R12 bridges
    do_reset(); set_fault(FK_BAND, 5, 9, 0, 0);
    wr(5, 1); rd(5, 0, "R12"); wr(9, 1); rd(9, 0, "R12"); idle(2);
    do_reset(); set_fault(FK_BOR, 5, 9, 0, 0);
    wr(5, 1); rd(9, 1, "R12"); wr(9, 0); rd(9, 1, "R12"); rd(5, 1, "R12"); idle(3);

    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d reads outstanding, expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule